// File: doc/BRIEF.md
# Mailbox Command Handshake Engine

This block is the host side of a shared register mailbox through which a coprocessor is asked to act on a request buffer. A single start pulse makes it run one full exchange. It confirms that the coprocessor is not in recovery and waits until the mailbox reports idle. It then stores the 64-bit buffer address, writes the command code into the control word and waits for the coprocessor to finish. Last, it reads back the status field.

When the exchange ends, the engine raises `done` for one cycle and presents one of five result codes. Software or a higher-level sequencer can use the code to tell a dead mailbox from a busy one, a hung coprocessor, or a request the coprocessor rejected. Both wait phases have a time limit set in clock cycles by `TIMEOUT_CYCLES`. The command code is set by `CMD_CODE`, which defaults to 0x64, the bus request.

The mailbox is reached through a plain register port with three word slots: 0 is the control word, 1 is the low address word and 2 is the high address word. Read data is returned on the clock after a read request.

Top module: `mbx_cmd_engine`

## Requirements
- R1: After reset, `done`, `busy`, `mb_rd` and `mb_we` are low and `result` is 0 (ok).
- R2: A start pulse is taken only while `busy` is low. The first mailbox access of an exchange is a read of slot 0. A start pulse given while `busy` is high is ignored: it causes no further exchange and no further `done`.
- R3: If bit 30 (recovery) of the first control read is 1, the exchange ends with result 1 (recovery error) and the engine writes nothing to the mailbox.
- R4: The mailbox counts as idle only when the whole control word reads exactly 0x8000_0000 (bit 31 set, all other bits clear). Every other value, including values with bit 31 set, keeps the engine polling.
- R5: If the mailbox is not idle within `TIMEOUT_CYCLES` cycles of the pre-issue wait, the exchange ends with result 2 (busy), no earlier than `TIMEOUT_CYCLES` cycles after start, and with no mailbox write.
- R6: Once the mailbox is idle, the engine makes three writes on consecutive cycles in this order: slot 1 gets address bits 31:0, slot 2 gets address bits 63:32, and slot 0 gets `{8'h00, CMD_CODE, 16'h0000}`. The address is the value on `buf_addr` when start was taken.
- R7: If the mailbox does not become idle within `TIMEOUT_CYCLES` cycles of the post-issue wait, the exchange ends with result 3 (timeout).
- R8: After completion, one more read of slot 0 is made. A nonzero bits 15:0 gives result 4 (status error), and zero gives result 0 (ok).
- R9: `done` is high for exactly one cycle per exchange. `result` changes only in the cycle `done` is high and holds its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins one exchange |
| buf_addr | input | 64 | Request buffer address, captured at start |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle end-of-exchange pulse |
| result | output | 3 | 0 ok, 1 recovery, 2 busy, 3 timeout, 4 status error |
| mb_rd | output | 1 | Mailbox read request |
| mb_we | output | 1 | Mailbox write strobe |
| mb_addr | output | 2 | Mailbox word slot: 0 control, 1 address low, 2 address high |
| mb_wdata | output | 32 | Mailbox write data |
| mb_rdata | input | 32 | Mailbox read data, valid the cycle after `mb_rd` |

## Verification
The mailbox model plays a scripted series of control-word values, one per read. This lets each run pick a different exit from the engine.

- A script with the recovery bit set on the first read must end with no writes at all.
- A script of near-idle words, such as ready with a status bit set, ready with a command bit set, or ready with the recovery bit set, must not start the write phase. This is shown by counting the reads made before the first write.
- Scripts that never become idle before the command, or never become idle after it, separate the busy result from the timeout result.
- A script whose completion read is idle but whose following status read is nonzero separates the status-error result from ok.
- A second start pulse given in the middle of an exchange must leave the write log and the done count unchanged.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam logic [1:0] SLOT_CTRL = 2'd0;
  localparam logic [1:0] SLOT_LO   = 2'd1;
  localparam logic [1:0] SLOT_HI   = 2'd2;

  localparam logic [31:0] IDLE_WORD = 32'h8000_0000;

  typedef enum logic [2:0] {
    RES_OK       = 3'd0,
    RES_RECOVERY = 3'd1,
    RES_BUSY     = 3'd2,
    RES_TIMEOUT  = 3'd3,
    RES_STATUS   = 3'd4
  } mbx_res_e;

  typedef enum logic [3:0] {
    S_IDLE, S_REC_RD, S_REC_CHK, S_PRE_RD, S_PRE_CHK,
    S_WR_LO, S_WR_HI, S_WR_CMD, S_POST_RD, S_POST_CHK,
    S_STS_RD, S_STS_CHK
  } mbx_state_e;

  function automatic logic mbx_is_idle(input logic [31:0] w);
    return w == IDLE_WORD;
  endfunction

  function automatic logic mbx_in_recovery(input logic [31:0] w);
    return w[30];
  endfunction

  function automatic logic [15:0] mbx_status(input logic [31:0] w);
    return w[15:0];
  endfunction

  function automatic logic [31:0] mbx_cmd_word(input logic [7:0] code);
    return {8'h00, code, 16'h0000};
  endfunction

endpackage

// File: rtl/mbx_wait_timer.sv
module mbx_wait_timer #(
  parameter int TIMEOUT_CYCLES = 125_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expired
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIMIT);

  // R5
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT);

  // R7
  timer_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !expired);

endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
#(
  parameter logic [7:0] CMD_CODE = 8'h64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] buf_addr,
  input  logic [31:0] mb_rdata,
  input  logic        tmr_expired,
  output logic        tmr_clr,
  output logic        mb_rd,
  output logic        mb_we,
  output logic [1:0]  mb_addr,
  output logic [31:0] mb_wdata,
  output logic        fin,
  output mbx_res_e    fin_code,
  output logic        busy
);
  mbx_state_e state, nxt;
  logic [63:0] addr_q;
  logic        accept;
  logic        wrote_q;
  logic        rd_idle;

  assign accept  = start && (state == S_IDLE);
  assign rd_idle = mbx_is_idle(mb_rdata);
  assign busy    = (state != S_IDLE);

  always_comb begin
    nxt      = state;
    fin      = 1'b0;
    fin_code = RES_OK;
    unique case (state)
      S_IDLE:    if (start) nxt = S_REC_RD;
      S_REC_RD:  nxt = S_REC_CHK;
      S_REC_CHK: begin
        if (mbx_in_recovery(mb_rdata)) begin
          fin = 1'b1; fin_code = RES_RECOVERY; nxt = S_IDLE;
        end else nxt = S_PRE_RD;
      end
      S_PRE_RD:  nxt = S_PRE_CHK;
      S_PRE_CHK: begin
        if (rd_idle) nxt = S_WR_LO;
        else if (tmr_expired) begin
          fin = 1'b1; fin_code = RES_BUSY; nxt = S_IDLE;
        end else nxt = S_PRE_RD;
      end
      S_WR_LO:   nxt = S_WR_HI;
      S_WR_HI:   nxt = S_WR_CMD;
      S_WR_CMD:  nxt = S_POST_RD;
      S_POST_RD: nxt = S_POST_CHK;
      S_POST_CHK: begin
        if (rd_idle) nxt = S_STS_RD;
        else if (tmr_expired) begin
          fin = 1'b1; fin_code = RES_TIMEOUT; nxt = S_IDLE;
        end else nxt = S_POST_RD;
      end
      S_STS_RD:  nxt = S_STS_CHK;
      S_STS_CHK: begin
        fin = 1'b1;
        fin_code = (mbx_status(mb_rdata) != 16'h0) ? RES_STATUS : RES_OK;
        nxt = S_IDLE;
      end
      default:   nxt = S_IDLE;
    endcase
  end

  always_comb begin
    mb_rd    = 1'b0;
    mb_we    = 1'b0;
    mb_addr  = SLOT_CTRL;
    mb_wdata = '0;
    case (state)
      S_REC_RD, S_PRE_RD, S_POST_RD, S_STS_RD: mb_rd = 1'b1;
      S_WR_LO:  begin mb_we = 1'b1; mb_addr = SLOT_LO; mb_wdata = addr_q[31:0];  end
      S_WR_HI:  begin mb_we = 1'b1; mb_addr = SLOT_HI; mb_wdata = addr_q[63:32]; end
      S_WR_CMD: begin mb_we = 1'b1; mb_wdata = mbx_cmd_word(CMD_CODE); end
      default: ;
    endcase
  end

  // timer restarts at the entry of each wait phase
  assign tmr_clr = (state == S_REC_CHK) || (state == S_WR_CMD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      wrote_q <= 1'b0;
    end else begin
      state <= nxt;
      if (accept) begin
        addr_q  <= buf_addr;
        wrote_q <= 1'b0;
      end else if (mb_we) begin
        wrote_q <= 1'b1;
      end
    end
  end

  // R2
  port_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mb_rd && mb_we));

  // R6
  hi_after_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_we && mb_addr == SLOT_HI) |-> $past(mb_we && mb_addr == SLOT_LO));

  // R6
  cmd_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_we && mb_addr == SLOT_CTRL) |-> $past(mb_we && mb_addr == SLOT_HI));

  // R3
  recovery_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && fin_code == RES_RECOVERY) |-> !wrote_q);

  // R5
  busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && fin_code == RES_BUSY) |-> !wrote_q);

  // R2
  first_access_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mb_rd && mb_addr == SLOT_CTRL));

endmodule

// File: rtl/mbx_result.sv
module mbx_result
  import mbx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fin,
  input  mbx_res_e fin_code,
  output logic     done,
  output mbx_res_e result
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= RES_OK;
    end else begin
      done <= fin;
      if (fin) result <= fin_code;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

endmodule

// File: rtl/mbx_cmd_engine.sv
module mbx_cmd_engine
  import mbx_pkg::*;
#(
  parameter int         TIMEOUT_CYCLES = 125_000_000,
  parameter logic [7:0] CMD_CODE       = 8'h64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] buf_addr,
  output logic        busy,
  output logic        done,
  output logic [2:0]  result,
  output logic        mb_rd,
  output logic        mb_we,
  output logic [1:0]  mb_addr,
  output logic [31:0] mb_wdata,
  input  logic [31:0] mb_rdata
);
  logic     tmr_clr;
  logic     tmr_expired;
  logic     fin;
  mbx_res_e fin_code;
  mbx_res_e res_q;

  mbx_wait_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmr_clr),
    .expired (tmr_expired)
  );

  mbx_seq #(.CMD_CODE(CMD_CODE)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .buf_addr    (buf_addr),
    .mb_rdata    (mb_rdata),
    .tmr_expired (tmr_expired),
    .tmr_clr     (tmr_clr),
    .mb_rd       (mb_rd),
    .mb_we       (mb_we),
    .mb_addr     (mb_addr),
    .mb_wdata    (mb_wdata),
    .fin         (fin),
    .fin_code    (fin_code),
    .busy        (busy)
  );

  mbx_result u_result (
    .clk      (clk),
    .rst_n    (rst_n),
    .fin      (fin),
    .fin_code (fin_code),
    .done     (done),
    .result   (res_q)
  );

  assign result = res_q;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mb_rd && !mb_we));

endmodule

// File: tb/mbx_cmd_engine_test.sv
`timescale 1ns/1ps
module mbx_cmd_engine_test;
  localparam int TMO = 20;
  localparam logic [31:0] CMDW = 32'h0064_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] buf_addr = '0;
  logic        busy, done;
  logic [2:0]  result;
  logic        mb_rd, mb_we;
  logic [1:0]  mb_addr;
  logic [31:0] mb_wdata;
  logic [31:0] mb_rdata;

  always #2 clk = ~clk;

  mbx_cmd_engine #(.TIMEOUT_CYCLES(TMO), .CMD_CODE(8'h64)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .buf_addr(buf_addr),
    .busy(busy), .done(done), .result(result),
    .mb_rd(mb_rd), .mb_we(mb_we), .mb_addr(mb_addr),
    .mb_wdata(mb_wdata), .mb_rdata(mb_rdata)
  );

  // scripted mailbox model
  logic [31:0] script [16];
  logic        mdl_clr = 1'b0;
  int          rd_idx, wr_n, first_wr_rd, cyc, done_cnt;
  logic [1:0]  wr_slot [8];
  logic [31:0] wr_dat  [8];
  int          wr_cyc  [8];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mdl_clr) begin
      rd_idx <= 0; wr_n <= 0; first_wr_rd <= -1; done_cnt <= 0;
      mb_rdata <= '0;
    end else begin
      if (mb_rd) begin
        mb_rdata <= script[(rd_idx > 15) ? 15 : rd_idx];
        rd_idx <= rd_idx + 1;
      end
      if (mb_we && wr_n < 8) begin
        wr_slot[wr_n] <= mb_addr;
        wr_dat[wr_n]  <= mb_wdata;
        wr_cyc[wr_n]  <= cyc;
        wr_n <= wr_n + 1;
        if (wr_n == 0) first_wr_rd <= rd_idx;
      end
      if (done) done_cnt <= done_cnt + 1;
    end
  end

  int checks = 0, errors = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] v [6], input int n, input logic [31:0] tail);
    for (int i = 0; i < 16; i++) script[i] = (i < n) ? v[i] : tail;
  endtask

  int lat;
  logic [2:0] prev_res;

  // runs one exchange; optional second start pulse mid-flight
  task automatic run(input logic [63:0] addr, input bit again);
    @(negedge clk) mdl_clr = 1'b1;
    @(negedge clk) mdl_clr = 1'b0;
    prev_res = result;
    buf_addr = addr; start = 1'b1;
    @(negedge clk) start = 1'b0;
    buf_addr = ~addr;
    check("R9 result held at start", result, prev_res);
    lat = 1;
    while (!done && lat < 500) begin
      @(negedge clk);
      lat++;
      if (again && lat == 4) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 done", done, 0);
    check("R1 busy", busy, 0);
    check("R1 result", result, 0);
    check("R1 mb_rd/mb_we", {mb_rd, mb_we}, 0);
  endtask

  task automatic t_ok;
    logic [31:0] v [6] = '{32'h0, 32'h8000_0000, CMDW, CMDW, 32'h8000_0000, 32'h8000_0000};
    logic [2:0] r;
    fill(v, 6, 32'h8000_0000);
    run(64'h1234_5678_9ABC_DEF0, 0);
    check("R8 ok result", result, 0);
    check("R6 write count", wr_n, 3);
    check("R6 slot lo", wr_slot[0], 1);
    check("R6 data lo", wr_dat[0], 32'h9ABC_DEF0);
    check("R6 slot hi", wr_slot[1], 2);
    check("R6 data hi", wr_dat[1], 32'h1234_5678);
    check("R6 slot ctrl", wr_slot[2], 0);
    check("R6 command word", wr_dat[2], CMDW);
    check("R6 consecutive", {wr_cyc[1] - wr_cyc[0], wr_cyc[2] - wr_cyc[1]}, {32'd1, 32'd1});
    check("R2 reads before writes", first_wr_rd, 2);
    check("R8 total reads", rd_idx, 6);
    r = result;
    @(negedge clk);
    check("R9 done one cycle", done, 0);
    repeat (5) @(negedge clk);
    check("R9 result held", result, r);
    check("R9 single done", done_cnt, 1);
  endtask

  task automatic t_recovery;
    logic [31:0] v [6] = '{32'h4000_0000, 32'h8000_0000, 32'h0, 32'h0, 32'h0, 32'h0};
    fill(v, 2, 32'h8000_0000);
    run(64'hAAAA_0000_5555_0000, 0);
    check("R3 recovery result", result, 1);
    @(negedge clk);
    check("R3 no writes", wr_n, 0);
    check("R3 one read", rd_idx, 1);
  endtask

  task automatic t_exact_idle;
    logic [31:0] v [6] = '{32'h0, 32'h8000_0001, 32'h8001_0000, 32'hC000_0000, 32'h0, 32'h8000_0000};
    fill(v, 6, 32'h8000_0000);
    run(64'h0000_0001_0000_0002, 0);
    check("R4 reads before first write", first_wr_rd, 6);
    check("R4 result", result, 0);
  endtask

  task automatic t_pre_busy;
    logic [31:0] v [6] = '{32'h0, 32'h1, 32'h1, 32'h1, 32'h1, 32'h1};
    fill(v, 6, 32'h0000_0001);
    run(64'h0000_0000_0000_1000, 0);
    check("R5 busy result", result, 2);
    check("R5 no writes", wr_n, 0);
    check("R5 waited long enough", (lat >= TMO), 1);
  endtask

  task automatic t_post_timeout;
    logic [31:0] v [6] = '{32'h0, 32'h8000_0000, CMDW, CMDW, CMDW, CMDW};
    fill(v, 6, CMDW);
    run(64'h0000_0000_0000_2000, 0);
    check("R7 timeout result", result, 3);
    check("R7 writes made", wr_n, 3);
    check("R7 waited long enough", (lat >= TMO), 1);
  endtask

  task automatic t_status_err;
    logic [31:0] v [6] = '{32'h0, 32'h8000_0000, CMDW, 32'h8000_0000, 32'h8000_0007, 32'h0};
    fill(v, 5, 32'h8000_0007);
    run(64'h0000_0000_0000_3000, 0);
    check("R8 status error result", result, 4);
  endtask

  task automatic t_start_ignored;
    logic [31:0] v [6] = '{32'h0, 32'h8000_0000, CMDW, 32'h8000_0000, 32'h8000_0000, 32'h0};
    fill(v, 5, 32'h8000_0000);
    run(64'h0000_0000_0000_4000, 1);
    repeat (12) @(negedge clk);
    check("R2 busy start: writes", wr_n, 3);
    check("R2 busy start: done count", done_cnt, 1);
    check("R2 back to idle", busy, 0);
  endtask

  task automatic finish_run;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    mdl_clr = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    mdl_clr = 1'b0;
    @(negedge clk);
    t_reset();
    t_ok();
    t_recovery();
    t_exact_idle();
    t_pre_busy();
    t_post_timeout();
    t_status_err();
    t_ok();
    t_start_ignored();
    finish_run();
  end

endmodule